// File: doc/BRIEF.md
# Event Combiner and Core Interrupt Selector

This block takes a wide bank of peripheral event lines and turns them into the twelve maskable interrupt levels of a processor core. The levels are numbered 4 to 15, and output bit i stands for level 4+i. Every event input has a sticky flag. The flag is set when the input rises and stays set until software clears it. The events are split into groups of 32, and each group feeds one combiner. A combiner ORs together the flags in its group that are enabled and not routed elsewhere. Each combiner output goes to one core level, and software picks that level.

Event numbers 0 to 3 are taken by the four combined outputs themselves. The matching input lines are therefore never flagged. A selector table with one entry per core level lets software send a single event, numbered 4 or above, straight to that level. An event routed this way is removed from its combiner, and it ignores its mask bit. When several sources land on the same level, they are ORed together.

Configuration goes through a plain write/read port. Writes are single-cycle strobes, and read data is combinational on the address. Register offsets, in word units, with g the combiner index and j the level index:
- Flags of group g, read-only: offset g.
- Write-1-to-clear register of group g: offset 4+g.
- Enable mask of group g: offset 8+g.
- Level code of combiner g: offset 12+g.
- Route entry j: offset 16+j.

Top module: `intr_event_router`

## Requirements
- R1: After reset, all flags and enable masks read 0, all route entries read 0, the level code of combiner g reads 8+g, and core_irq is 0.
- R2: A rising edge on evt_in[k], for k of 4 or more, sets flag k. The flag is visible in flag register k/32 at bit k%32, and in core_irq, right after the next clock edge. It stays set after the input falls.
- R3: Writing 1s to the clear register at offset 4+g clears those flag bits of group g. If a rising edge reaches the same flag in the same cycle, the set wins.
- R4: evt_in[3:0] are ignored. Flags 0 to 3 always read 0.
- R5: The output of combiner g is the OR of flag AND mask over events 32g to 32g+31. The mask sits at offset 8+g, and a mask bit of 1 enables the event. Masking acts on the output only and leaves the flag unchanged.
- R6: Level code c of combiner g (offset 12+g, 4 bits) drives core_irq[c] when c is 0 to 11. Codes 12 to 15 drive no level.
- R7: Route entry j (offset 16+j, 7 bits) holding v from 4 to 127 drives core_irq[j] with flag v, regardless of that event's mask bit.
- R8: An event named by any valid route entry no longer contributes to its combiner.
- R9: A route entry holding 0 to 3 is stored and reads back as written, but it drives no level and removes no event.
- R10: When several sources map to one level, combiners and routed events alike, that level is their OR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 128 | Peripheral event lines; bits 3:0 unused |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| core_irq | output | 12 | Core interrupt levels 4 to 15, bit 0 is level 4 |

## Verification
Flags are the only state between an event line and core_irq, so an input rise that is sampled at one clock edge shows up in the flags and in core_irq one edge later. The bench drives every input on a falling edge and checks on the next falling edge, one rising edge later. Configuration writes and clears take effect at the rising edge that samples them, so each result is checked on the falling edge that follows. Register reads are combinational: the bench sets the address, waits a short delay, and samples, with no clock edge in between. The main sweep pulses every event from 4 to 127 in turn and works out the expected level and flag bit from the event number.

// File: rtl/intr_rt_pkg.sv
package intr_rt_pkg;

   // Which register block a configuration address falls into
   typedef enum logic [2:0] {
      BLK_FLAG,
      BLK_CLR,
      BLK_MASK,
      BLK_LVL,
      BLK_ROUTE,
      BLK_NONE
   } reg_blk_e;

endpackage

// File: rtl/intr_rt_flag_grp.sv
// Edge-detected sticky flags for one group of events.
module intr_rt_flag_grp #(
   parameter int GRP_W   = 32,
   parameter int IGN_LOW = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [GRP_W-1:0] evt,
   input  logic [GRP_W-1:0] clr,
   output logic [GRP_W-1:0] evt_q,
   output logic [GRP_W-1:0] flag_q
);
   localparam logic [GRP_W-1:0] KEEP = {GRP_W{1'b1}} << IGN_LOW;

   logic [GRP_W-1:0] rise;
   logic [GRP_W-1:0] flag_d;

   always_comb begin
      rise   = evt & ~evt_q & KEEP;
      // a rising edge in the same cycle as a clear wins
      flag_d = ((flag_q & ~clr) | rise) & KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q  <= '0;
         flag_q <= '0;
      end else begin
         evt_q  <= evt & KEEP;
         flag_q <= flag_d;
      end
   end
endmodule

// File: rtl/intr_rt_combiner.sv
// One event combiner: OR of enabled, flagged, not-bypassed events.
module intr_rt_combiner #(
   parameter int GRP_W = 32
) (
   input  logic [GRP_W-1:0] flag,
   input  logic [GRP_W-1:0] mask,
   input  logic [GRP_W-1:0] bypass,
   output logic             comb_out
);
   always_comb comb_out = |(flag & mask & ~bypass);
endmodule

// File: rtl/intr_rt_route.sv
// Direct route table: each level may take one event straight from its flag.
module intr_rt_route #(
   parameter int NUM_EVT = 128,
   parameter int NUM_LVL = 12,
   parameter int NUM_CMB = 4,
   localparam int EVT_W  = $clog2(NUM_EVT)
) (
   input  logic [NUM_EVT-1:0]              flag,
   input  logic [NUM_LVL-1:0][EVT_W-1:0]   route,
   output logic [NUM_LVL-1:0]              direct_irq,
   output logic [NUM_EVT-1:0]              routed
);
   logic [NUM_LVL-1:0] valid;

   genvar j;
   generate
      for (j = 0; j < NUM_LVL; j++) begin : g_ent
         // entries naming a combined output are ignored
         assign valid[j]      = (int'(route[j]) >= NUM_CMB);
         assign direct_irq[j] = valid[j] & flag[route[j]];
      end
   endgenerate

   always_comb begin
      routed = '0;
      for (int k = 0; k < NUM_LVL; k++) begin
         if (valid[k]) routed[route[k]] = 1'b1;
      end
   end
endmodule

// File: rtl/intr_rt_cfg.sv
// Configuration registers: masks, level codes, route entries, clear strobes, read mux.
module intr_rt_cfg
   import intr_rt_pkg::*;
#(
   parameter int NUM_EVT = 128,
   parameter int GRP_W   = 32,
   parameter int NUM_LVL = 12,
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32,
   localparam int NUM_CMB = NUM_EVT / GRP_W,
   localparam int EVT_W   = $clog2(NUM_EVT),
   localparam int LVL_W   = $clog2(NUM_LVL + 1)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_wr,
   input  logic [ADDR_W-1:0]               cfg_addr,
   input  logic [DATA_W-1:0]               cfg_wdata,
   input  logic [NUM_EVT-1:0]              flag_q,
   output logic [DATA_W-1:0]               cfg_rdata,
   output logic [NUM_EVT-1:0]              mask_q,
   output logic [NUM_CMB-1:0][LVL_W-1:0]   lvl_q,
   output logic [NUM_LVL-1:0][EVT_W-1:0]   route_q,
   output logic [NUM_EVT-1:0]              clr_vec
);
   localparam int A_CLR   = NUM_CMB;
   localparam int A_MASK  = 2 * NUM_CMB;
   localparam int A_LVL   = 3 * NUM_CMB;
   localparam int A_ROUTE = 4 * NUM_CMB;
   localparam int A_END   = A_ROUTE + NUM_LVL;

   reg_blk_e blk;
   int       idx;

   always_comb begin
      int a;
      a   = int'(cfg_addr);
      blk = BLK_NONE;
      idx = 0;
      if (a < A_CLR) begin
         blk = BLK_FLAG;
         idx = a;
      end else if (a < A_MASK) begin
         blk = BLK_CLR;
         idx = a - A_CLR;
      end else if (a < A_LVL) begin
         blk = BLK_MASK;
         idx = a - A_MASK;
      end else if (a < A_ROUTE) begin
         blk = BLK_LVL;
         idx = a - A_LVL;
      end else if (a < A_END) begin
         blk = BLK_ROUTE;
         idx = a - A_ROUTE;
      end
   end

   // write-one-to-clear strobes, valid only in the write cycle
   always_comb begin
      clr_vec = '0;
      if (cfg_wr && blk == BLK_CLR)
         clr_vec[idx*GRP_W +: GRP_W] = cfg_wdata[GRP_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         route_q <= '0;
         for (int g = 0; g < NUM_CMB; g++)
            lvl_q[g] <= LVL_W'(NUM_LVL - NUM_CMB + g);
      end else if (cfg_wr) begin
         case (blk)
            BLK_MASK:  mask_q[idx*GRP_W +: GRP_W] <= cfg_wdata[GRP_W-1:0];
            BLK_LVL:   lvl_q[idx]   <= cfg_wdata[LVL_W-1:0];
            BLK_ROUTE: route_q[idx] <= cfg_wdata[EVT_W-1:0];
            default:   ;
         endcase
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (blk)
         BLK_FLAG:  cfg_rdata = DATA_W'(flag_q[idx*GRP_W +: GRP_W]);
         BLK_MASK:  cfg_rdata = DATA_W'(mask_q[idx*GRP_W +: GRP_W]);
         BLK_LVL:   cfg_rdata = DATA_W'(lvl_q[idx]);
         BLK_ROUTE: cfg_rdata = DATA_W'(route_q[idx]);
         default:   cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/intr_event_router.sv
module intr_event_router #(
   parameter int NUM_EVT = 128,
   parameter int GRP_W   = 32,
   parameter int NUM_LVL = 12,
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32,
   parameter bit REG_OUT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic               cfg_wr,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [DATA_W-1:0]  cfg_wdata,
   output logic [DATA_W-1:0]  cfg_rdata,
   output logic [NUM_LVL-1:0] core_irq
);
   localparam int NUM_CMB = NUM_EVT / GRP_W;
   localparam int EVT_W   = $clog2(NUM_EVT);
   localparam int LVL_W   = $clog2(NUM_LVL + 1);
   localparam int REGS    = 4 * NUM_CMB + NUM_LVL;

   generate
      if (NUM_CMB * GRP_W != NUM_EVT || (1 << EVT_W) != NUM_EVT) begin : g_bad_evt
         $error("NUM_EVT must be a power of two and a multiple of GRP_W");
      end
      if (NUM_CMB > NUM_LVL || NUM_CMB > GRP_W) begin : g_bad_cmb
         $error("too many combiners for the level count or group width");
      end
      if (GRP_W > DATA_W || EVT_W > DATA_W) begin : g_bad_data
         $error("DATA_W too narrow for a group or an event number");
      end
      if ((1 << ADDR_W) < REGS) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [NUM_EVT-1:0]            evt_q;
   logic [NUM_EVT-1:0]            flag_q;
   logic [NUM_EVT-1:0]            mask_q;
   logic [NUM_EVT-1:0]            clr_vec;
   logic [NUM_EVT-1:0]            routed;
   logic [NUM_CMB-1:0][LVL_W-1:0] lvl_q;
   logic [NUM_LVL-1:0][EVT_W-1:0] route_q;
   logic [NUM_LVL-1:0]            direct_irq;
   logic [NUM_CMB-1:0]            comb_out;
   logic [NUM_LVL-1:0]            irq_d;

   intr_rt_cfg #(
      .NUM_EVT (NUM_EVT),
      .GRP_W   (GRP_W),
      .NUM_LVL (NUM_LVL),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .flag_q    (flag_q),
      .cfg_rdata (cfg_rdata),
      .mask_q    (mask_q),
      .lvl_q     (lvl_q),
      .route_q   (route_q),
      .clr_vec   (clr_vec)
   );

   genvar g;
   generate
      for (g = 0; g < NUM_CMB; g++) begin : g_grp
         // group 0 holds the event numbers taken by the combined outputs
         intr_rt_flag_grp #(
            .GRP_W   (GRP_W),
            .IGN_LOW ((g == 0) ? NUM_CMB : 0)
         ) u_flags (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_in [g*GRP_W +: GRP_W]),
            .clr    (clr_vec[g*GRP_W +: GRP_W]),
            .evt_q  (evt_q  [g*GRP_W +: GRP_W]),
            .flag_q (flag_q [g*GRP_W +: GRP_W])
         );

         intr_rt_combiner #(
            .GRP_W (GRP_W)
         ) u_comb (
            .flag     (flag_q[g*GRP_W +: GRP_W]),
            .mask     (mask_q[g*GRP_W +: GRP_W]),
            .bypass   (routed[g*GRP_W +: GRP_W]),
            .comb_out (comb_out[g])
         );
      end
   endgenerate

   intr_rt_route #(
      .NUM_EVT (NUM_EVT),
      .NUM_LVL (NUM_LVL),
      .NUM_CMB (NUM_CMB)
   ) u_route (
      .flag       (flag_q),
      .route      (route_q),
      .direct_irq (direct_irq),
      .routed     (routed)
   );

   // fan combiner outputs onto their programmed levels and merge with direct routes
   always_comb begin
      irq_d = direct_irq;
      for (int c = 0; c < NUM_CMB; c++) begin
         for (int l = 0; l < NUM_LVL; l++) begin
            if (int'(lvl_q[c]) == l && comb_out[c]) irq_d[l] = 1'b1;
         end
      end
   end

   generate
      if (REG_OUT) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) core_irq <= '0;
            else        core_irq <= irq_d;
         end
      end else begin : g_out_comb
         assign core_irq = irq_d;
      end
   endgenerate
endmodule

// File: rtl/intr_event_router_chk.sv
module intr_event_router_chk #(
   parameter int NUM_EVT = 128,
   parameter int NUM_LVL = 12,
   parameter int NUM_CMB = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_EVT-1:0] evt_in,
   input logic [NUM_EVT-1:0] evt_q,
   input logic [NUM_EVT-1:0] flag_q,
   input logic [NUM_EVT-1:0] clr_vec,
   input logic [NUM_LVL-1:0] core_irq
);
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((flag_q & ~$past(flag_q) & ~($past(evt_in) & ~$past(evt_q))) == '0)); // R2

   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (($past(flag_q) & ~$past(clr_vec) & ~flag_q) == '0)); // R2

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((flag_q & $past(clr_vec) & ~($past(evt_in) & ~$past(evt_q))) == '0)); // R3

   AST_LOW_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[NUM_CMB-1:0] == '0); // R4

   AST_QUIET_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(flag_q) == '0 && flag_q == '0) |-> (core_irq == '0)); // R5
endmodule

bind intr_event_router intr_event_router_chk #(
   .NUM_EVT (NUM_EVT),
   .NUM_LVL (NUM_LVL),
   .NUM_CMB (NUM_CMB)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .evt_in   (evt_in),
   .evt_q    (evt_q),
   .flag_q   (flag_q),
   .clr_vec  (clr_vec),
   .core_irq (core_irq)
);

// File: tb/tb_intr_event_router.sv
module tb_intr_event_router;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_EVT = 128;
   localparam int NUM_LVL = 12;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NUM_EVT-1:0] evt_in = '0;
   logic               cfg_wr = 1'b0;
   logic [4:0]         cfg_addr = '0;
   logic [31:0]        cfg_wdata = '0;
   logic [31:0]        cfg_rdata;
   logic [NUM_LVL-1:0] core_irq;

   int checks = 0;
   int errors = 0;

   intr_event_router dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_in    (evt_in),
      .cfg_wr    (cfg_wr),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .core_irq  (core_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [31:0] data);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_addr = 5'(addr);
      cfg_wdata = data;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(input int addr, output logic [31:0] data);
      cfg_addr = 5'(addr);
      #1;
      data = cfg_rdata;
   endtask

   task automatic pulse(input int k);
      @(negedge clk);
      evt_in[k] = 1'b1;
      @(negedge clk);
      evt_in[k] = 1'b0;
   endtask

   function automatic logic [31:0] bit32(input int n);
      return 32'(1) << n;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", 32'(core_irq), 0);
      for (int g = 0; g < 4; g++) begin
         rd(g, d);      check("R1 flag", d, 0);
         rd(8 + g, d);  check("R1 mask", d, 0);
         rd(12 + g, d); check("R1 level", d, 32'(8 + g));
      end
      for (int j = 0; j < 12; j++) begin
         rd(16 + j, d); check("R1 route", d, 0);
      end

      for (int g = 0; g < 4; g++) wr(8 + g, 32'hFFFF_FFFF);

      // R2 R3 R5 sweep every real event
      for (int k = 4; k < NUM_EVT; k++) begin
         pulse(k);
         check("R5 level of group", 32'(core_irq), bit32(8 + k / 32));
         rd(k / 32, d);
         check("R2 flag bit", d, bit32(k % 32));
         wr(4 + k / 32, bit32(k % 32));
         check("R3 cleared", 32'(core_irq), 0);
      end

      // R4 low inputs ignored
      @(negedge clk); evt_in[3:0] = 4'hF;
      @(negedge clk); evt_in[3:0] = 4'h0;
      check("R4 irq", 32'(core_irq), 0);
      rd(0, d); check("R4 flags", d, 0);

      // R2 sticky after input falls
      pulse(60);
      repeat (5) @(negedge clk);
      check("R2 sticky irq", 32'(core_irq), bit32(9));
      rd(1, d); check("R2 sticky flag", d, bit32(28));
      wr(5, 32'hFFFF_FFFF);

      // R3 set wins over simultaneous clear
      @(negedge clk);
      evt_in[50] = 1'b1;
      cfg_wr = 1'b1; cfg_addr = 5'd5; cfg_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      cfg_wr = 1'b0;
      rd(1, d); check("R3 set wins", d, bit32(18));
      wr(5, 32'hFFFF_FFFF);
      rd(1, d); check("R3 clear while high", d, 0);
      check("R3 irq after clear", 32'(core_irq), 0);
      evt_in[50] = 1'b0;

      // R6 level code reassignment
      wr(13, 0);
      pulse(40);
      check("R6 code 0", 32'(core_irq), bit32(0));
      wr(13, 13);
      check("R6 code none", 32'(core_irq), 0);
      rd(1, d); check("R6 flag kept", d, bit32(8));
      wr(5, 32'hFFFF_FFFF);
      wr(13, 9);

      // R5 masking hides output but keeps flag
      wr(10, 0);
      pulse(70);
      check("R5 masked", 32'(core_irq), 0);
      rd(2, d); check("R5 flag under mask", d, bit32(6));
      wr(10, 32'hFFFF_FFFF);
      check("R5 unmasked", 32'(core_irq), bit32(10));
      wr(6, 32'hFFFF_FFFF);

      // R7 direct route ignores mask, R8 bypasses combiner
      wr(10, 0);
      wr(21, 70);
      rd(21, d); check("R7 route readback", d, 70);
      pulse(70);
      check("R7 direct", 32'(core_irq), bit32(5));
      wr(10, 32'hFFFF_FFFF);
      check("R8 bypass", 32'(core_irq), bit32(5));
      pulse(71);
      check("R8 others still combine", 32'(core_irq), bit32(5) | bit32(10));
      wr(6, 32'hFFFF_FFFF);
      check("R7 cleared", 32'(core_irq), 0);
      wr(21, 0);

      // R9 entries naming combined outputs are ignored
      wr(23, 1);
      rd(23, d); check("R9 stored", d, 1);
      pulse(10);
      check("R9 no drive", 32'(core_irq), bit32(8));
      wr(4, 32'hFFFF_FFFF);
      wr(23, 0);

      // R10 shared level
      wr(12, 9);
      wr(25, 100);
      pulse(5);
      check("R10 combiner on shared", 32'(core_irq), bit32(9));
      wr(4, 32'hFFFF_FFFF);
      check("R10 cleared", 32'(core_irq), 0);
      pulse(100);
      check("R10 route on shared", 32'(core_irq), bit32(9));
      pulse(5);
      check("R10 both", 32'(core_irq), bit32(9));
      wr(7, bit32(4));
      check("R10 one left", 32'(core_irq), bit32(9));
      wr(4, 32'hFFFF_FFFF);
      check("R10 none left", 32'(core_irq), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule